// File: doc/BRIEF.md
# Global History Branch Direction Predictor

This block predicts whether a conditional branch will be taken. It keeps one shift register of recent branch outcomes, shared by every branch whatever its address, and a table of 2-bit saturating counters. At fetch it forms a table index from the history and the fetch address, and returns the predicted direction, the index and the counter value it read. The mode input selects how the index is formed. It can be the history alone, the history XORed with address bits, or history bits placed beside address bits. The pipeline carries the index and counter with the instruction.

When the instruction resolves, the pipeline returns the carried index and counter, a flag saying whether the instruction was a branch, and the actual outcome. For a branch, the block writes the stepped counter back at the carried index. It also shifts the outcome into the history register. Because the index travels with the instruction, later history changes cannot redirect the update. Repairing speculative history after a misprediction is left to the surrounding pipeline.

Each table entry is a four-state machine of type `ctr_state_t`. The states are CTR_STRONG_NT (0), CTR_WEAK_NT (1), CTR_WEAK_T (2) and CTR_STRONG_T (3). A taken outcome steps STRONG_NT to WEAK_NT, WEAK_NT to WEAK_T, WEAK_T to STRONG_T, and STRONG_T to itself. A not-taken outcome steps the other way and holds in STRONG_NT. The two taken states predict taken.

Top module: `ghist_predictor`

## Requirements
- R1: Reset clears the history register and every counter to 0, so that right after reset a fetch in mode 2'b00 returns index 0, counter 0 and not-taken.
- R2: When `idx_mode_i` is 2'b00 or 2'b11, `pred_idx_o` equals the history register.
- R3: When `idx_mode_i` is 2'b01, `pred_idx_o` equals the history register XORed with `fetch_pc_i[ALIGN+IDX_W-1:ALIGN]`.
- R4: When `idx_mode_i` is 2'b10, `pred_idx_o` is formed from two parts. Its upper IDX_W-IDX_W/2 bits are the lowest fetch address bits above the alignment field. Its lower IDX_W/2 bits are the lowest history bits.
- R5: `pred_ctr_o` is the counter stored at `pred_idx_o`, read in the same cycle, and `pred_taken_o` is 1 exactly when that counter is 2 or 3.
- R6: When `res_branch_i` is 1, the entry at `res_idx_i` becomes `res_ctr_i` plus 1 if `res_taken_i` is 1, or minus 1 otherwise. The new value can be read from the next cycle on, whatever the history has done since the fetch.
- R7: Counter updates saturate: a taken outcome on a carried value of 3 writes 3, and a not-taken outcome on a carried value of 0 writes 0.
- R8: When `res_branch_i` is 1, the history register shifts left by one, with `res_taken_i` entering bit 0.
- R9: When `res_branch_i` is 0, neither the history register nor any counter changes, whatever the values on the other resolve inputs.
- R10: In mode 2'b00, a branch that repeats the pattern taken, taken, taken, not-taken is predicted correctly at every position, including the not-taken exit, once the pattern has run for five rounds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| idx_mode_i | input | 2 | Index mode: 00 history, 01 XOR, 10 concatenate, 11 as 00 |
| fetch_pc_i | input | PC_W | Address of the instruction being fetched |
| pred_taken_o | output | 1 | Predicted direction, 1 = taken |
| pred_idx_o | output | IDX_W | Table index used for this prediction |
| pred_ctr_o | output | 2 | Counter value read at that index |
| res_branch_i | input | 1 | Resolving instruction is a branch; qualifies the update |
| res_taken_i | input | 1 | Resolved outcome, 1 = taken |
| res_idx_i | input | IDX_W | Index carried from fetch |
| res_ctr_i | input | 2 | Counter value carried from fetch |

## Verification
The hardest case to reach is an update whose carried index no longer matches what the current history would give. In that case only the carried index can land the write in the right entry. The stimulus fetches a branch and keeps its index. It then resolves three other taken branches to move the history, and only then resolves the first branch. The bench inspects the entry by picking a fetch address that maps onto it in XOR mode. It reaches the exit entry of a four-step loop by resetting first, so that earlier training cannot alias into the entries the loop uses.

// File: rtl/gbp_pkg.sv
package gbp_pkg;

    typedef enum logic [1:0] {
        CTR_STRONG_NT = 2'b00,
        CTR_WEAK_NT   = 2'b01,
        CTR_WEAK_T    = 2'b10,
        CTR_STRONG_T  = 2'b11
    } ctr_state_t;

    typedef enum logic [1:0] {
        IDX_HIST = 2'b00,
        IDX_XOR  = 2'b01,
        IDX_CAT  = 2'b10,
        IDX_RSVD = 2'b11
    } idx_mode_t;

endpackage

// File: rtl/gbp_ctr_next.sv
module gbp_ctr_next
    import gbp_pkg::*;
(
    input  ctr_state_t cur_i,
    input  logic       taken_i,
    output ctr_state_t nxt_o
);

    always_comb begin
        unique case (cur_i)
            CTR_STRONG_NT: nxt_o = taken_i ? CTR_WEAK_NT  : CTR_STRONG_NT;
            CTR_WEAK_NT:   nxt_o = taken_i ? CTR_WEAK_T   : CTR_STRONG_NT;
            CTR_WEAK_T:    nxt_o = taken_i ? CTR_STRONG_T : CTR_WEAK_NT;
            CTR_STRONG_T:  nxt_o = taken_i ? CTR_STRONG_T : CTR_WEAK_T;
        endcase
    end

endmodule

// File: rtl/gbp_index.sv
module gbp_index
    import gbp_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic [1:0]       mode_i,
    input  logic [IDX_W-1:0] ghr_i,
    input  logic [IDX_W-1:0] pc_bits_i,
    output logic [IDX_W-1:0] idx_o
);

    localparam int SEL_H = IDX_W / 2;
    localparam int SEL_P = IDX_W - SEL_H;

    logic [IDX_W-1:0] cat_idx;

    generate
        if (SEL_H > 0) begin : g_cat
            assign cat_idx = {pc_bits_i[SEL_P-1:0], ghr_i[SEL_H-1:0]};
        end else begin : g_cat_narrow
            assign cat_idx = pc_bits_i;
        end
    endgenerate

    always_comb begin
        unique case (idx_mode_t'(mode_i))
            IDX_XOR:            idx_o = ghr_i ^ pc_bits_i;
            IDX_CAT:            idx_o = cat_idx;
            IDX_HIST, IDX_RSVD: idx_o = ghr_i;
        endcase
    end

endmodule

// File: rtl/gbp_ghr.sv
module gbp_ghr #(
    parameter int HIST_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en_i,
    input  logic              bit_i,
    output logic [HIST_W-1:0] hist_o
);

    logic [HIST_W-1:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (shift_en_i) begin
            hist_q <= {hist_q[HIST_W-2:0], bit_i};
        end
    end

    assign hist_o = hist_q;

    AST_GHR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en_i |=> $stable(hist_q)); // R9

    AST_GHR_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en_i |=> (hist_q[0] == $past(bit_i)) &&
                       (hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0]))); // R8

endmodule

// File: rtl/gbp_pht.sv
module gbp_pht
    import gbp_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx_i,
    output ctr_state_t       rd_ctr_o,
    input  logic             wr_en_i,
    input  logic [IDX_W-1:0] wr_idx_i,
    input  ctr_state_t       wr_ctr_i
);

    localparam int DEPTH = 1 << IDX_W;

    logic [1:0] ent_vec [DEPTH];

    generate
        for (genvar e = 0; e < DEPTH; e++) begin : g_ent
            ctr_state_t ent_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    ent_q <= CTR_STRONG_NT;
                end else if (wr_en_i && (wr_idx_i == IDX_W'(e))) begin
                    ent_q <= wr_ctr_i;
                end
            end
            assign ent_vec[e] = ent_q;
        end
    endgenerate

    assign rd_ctr_o = ctr_state_t'(ent_vec[rd_idx_i]);

endmodule

// File: rtl/ghist_predictor.sv
module ghist_predictor
    import gbp_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int IDX_W = 6,
    parameter int ALIGN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       idx_mode_i,
    input  logic [PC_W-1:0]  fetch_pc_i,
    output logic             pred_taken_o,
    output logic [IDX_W-1:0] pred_idx_o,
    output logic [1:0]       pred_ctr_o,
    input  logic             res_branch_i,
    input  logic             res_taken_i,
    input  logic [IDX_W-1:0] res_idx_i,
    input  logic [1:0]       res_ctr_i
);

    localparam int PC_HI = ALIGN + IDX_W;

    logic [IDX_W-1:0] ghr;
    logic [IDX_W-1:0] pc_bits;
    logic [IDX_W-1:0] fetch_idx;
    ctr_state_t       rd_ctr;
    ctr_state_t       upd_ctr;
    logic             unused_pc;

    assign pc_bits   = fetch_pc_i[PC_HI-1:ALIGN];
    assign unused_pc = ^{fetch_pc_i[PC_W-1:PC_HI], fetch_pc_i[ALIGN-1:0]};

    gbp_ghr #(.HIST_W(IDX_W)) u_ghr (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift_en_i (res_branch_i),
        .bit_i      (res_taken_i),
        .hist_o     (ghr)
    );

    gbp_index #(.IDX_W(IDX_W)) u_index (
        .mode_i    (idx_mode_i),
        .ghr_i     (ghr),
        .pc_bits_i (pc_bits),
        .idx_o     (fetch_idx)
    );

    gbp_ctr_next u_next (
        .cur_i   (ctr_state_t'(res_ctr_i)),
        .taken_i (res_taken_i),
        .nxt_o   (upd_ctr)
    );

    gbp_pht #(.IDX_W(IDX_W)) u_pht (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx_i (fetch_idx),
        .rd_ctr_o (rd_ctr),
        .wr_en_i  (res_branch_i),
        .wr_idx_i (res_idx_i),
        .wr_ctr_i (upd_ctr)
    );

    always_comb begin
        pred_idx_o   = fetch_idx;
        pred_ctr_o   = rd_ctr;
        pred_taken_o = (rd_ctr == CTR_WEAK_T) || (rd_ctr == CTR_STRONG_T);
    end

    AST_SAT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(res_branch_i) && $past(res_taken_i) && ($past(res_ctr_i) == 2'd3) &&
         (pred_idx_o == $past(res_idx_i))) |-> (pred_ctr_o == 2'd3)); // R7

    AST_SAT_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(res_branch_i) && !$past(res_taken_i) && ($past(res_ctr_i) == 2'd0) &&
         (pred_idx_o == $past(res_idx_i))) |-> (pred_ctr_o == 2'd0)); // R7

    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(res_branch_i) && $past(res_taken_i) && ($past(res_ctr_i) != 2'd3) &&
         (pred_idx_o == $past(res_idx_i))) |-> (pred_ctr_o == $past(res_ctr_i) + 2'd1)); // R6

    AST_GAG_IDX: assert property (@(posedge clk) disable iff (!rst_n)
        ((idx_mode_i == 2'b00) && $past(res_branch_i)) |-> (pred_idx_o[0] == $past(res_taken_i))); // R2

endmodule

// File: tb/ghist_predictor_tb_top.sv
module ghist_predictor_tb_top;

    localparam int PC_W  = 32;
    localparam int IDX_W = 6;
    localparam int ALIGN = 2;
    localparam int DEPTH = 1 << IDX_W;
    localparam int MASK  = DEPTH - 1;
    localparam int SEL_H = IDX_W / 2;
    localparam int MAX_CYC = 100000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [1:0]       idx_mode_i = '0;
    logic [PC_W-1:0]  fetch_pc_i = '0;
    logic             pred_taken_o;
    logic [IDX_W-1:0] pred_idx_o;
    logic [1:0]       pred_ctr_o;
    logic             res_branch_i = 1'b0;
    logic             res_taken_i = 1'b0;
    logic [IDX_W-1:0] res_idx_i = '0;
    logic [1:0]       res_ctr_i = '0;

    int n_checks = 0;
    int n_errors = 0;

    int m_ghr;
    int m_pht [DEPTH];

    int    q_idx [$];
    int    q_ctr [$];
    string q_tag [$];

    always #10 clk = ~clk;

    ghist_predictor #(.PC_W(PC_W), .IDX_W(IDX_W), .ALIGN(ALIGN)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .idx_mode_i   (idx_mode_i),
        .fetch_pc_i   (fetch_pc_i),
        .pred_taken_o (pred_taken_o),
        .pred_idx_o   (pred_idx_o),
        .pred_ctr_o   (pred_ctr_o),
        .res_branch_i (res_branch_i),
        .res_taken_i  (res_taken_i),
        .res_idx_i    (res_idx_i),
        .res_ctr_i    (res_ctr_i)
    );

    function automatic int idx_of(input int mode, input logic [PC_W-1:0] pc);
        int pcb;
        pcb = int'(pc >> ALIGN) & MASK;
        case (mode)
            1:       return (m_ghr ^ pcb) & MASK;
            2:       return ((pcb << SEL_H) | (m_ghr & ((1 << SEL_H) - 1))) & MASK;
            default: return m_ghr;
        endcase
    endfunction

    function automatic int sat(input int c, input bit t);
        if (t) return (c == 3) ? 3 : c + 1;
        return (c == 0) ? 0 : c - 1;
    endfunction

    task automatic model_reset();
        m_ghr = 0;
        for (int i = 0; i < DEPTH; i++) m_pht[i] = 0;
    endtask

    // Monitor: pops the expected fetch result and compares it with the ports.
    always @(negedge clk) begin
        #5;
        while (q_idx.size() > 0) begin
            int    e_idx;
            int    e_ctr;
            string tg;
            e_idx = q_idx.pop_front();
            e_ctr = q_ctr.pop_front();
            tg    = q_tag.pop_front();
            n_checks++;
            if (int'(pred_idx_o) != e_idx || int'(pred_ctr_o) != e_ctr ||
                pred_taken_o != (e_ctr >= 2)) begin
                n_errors++;
                $display("FAIL %s: idx/ctr/taken = %0d/%0d/%0d, expected %0d/%0d/%0d",
                         tg, pred_idx_o, pred_ctr_o, pred_taken_o, e_idx, e_ctr, e_ctr >= 2);
            end
        end
    end

    // Driver: one fetch per cycle, optionally one resolve in the same cycle.
    task automatic cyc(input int mode, input logic [PC_W-1:0] pc,
                       input bit rb, input bit rt, input bit self_res,
                       input int ridx, input int rctr, input int want_dir,
                       input string tag, output int fidx, output int fctr);
        int ui;
        int uc;
        @(negedge clk);
        fidx = idx_of(mode, pc);
        fctr = m_pht[fidx];
        ui = self_res ? fidx : ridx;
        uc = self_res ? fctr : rctr;
        idx_mode_i   = mode[1:0];
        fetch_pc_i   = pc;
        res_branch_i = rb;
        res_taken_i  = rt;
        res_idx_i    = ui[IDX_W-1:0];
        res_ctr_i    = uc[1:0];
        q_idx.push_back(fidx);
        q_ctr.push_back(fctr);
        q_tag.push_back(tag);
        if (want_dir >= 0) begin
            #6;
            n_checks++;
            if (int'(pred_taken_o) != want_dir) begin
                n_errors++;
                $display("FAIL %s: direction %0d, expected %0d", tag, pred_taken_o, want_dir);
            end
        end
        @(posedge clk);
        if (rb) begin
            m_pht[ui] = sat(uc, rt);
            m_ghr = ((m_ghr << 1) | int'(rt)) & MASK;
        end
    endtask

    task automatic br(input int mode, input logic [PC_W-1:0] pc, input bit t, input string tag);
        int fi;
        int fc;
        cyc(mode, pc, 1'b1, t, 1'b1, 0, 0, -1, tag, fi, fc);
    endtask

    task automatic probe(input int idx, input string tag);
        int fi;
        int fc;
        logic [PC_W-1:0] pc;
        pc = PC_W'(((idx ^ m_ghr) & MASK) << ALIGN);
        cyc(1, pc, 1'b0, 1'b0, 1'b0, 0, 0, -1, tag, fi, fc);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        res_branch_i = 1'b0;
        model_reset();
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(20 * MAX_CYC);
        n_errors++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int a_idx;
        int a_ctr;
        int fi;
        int fc;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: state after reset
        cyc(0, 32'h0000_1234, 1'b0, 1'b0, 1'b0, 0, 0, 0, "R1 reset idx0", fi, fc);
        probe(45, "R1 reset entry 45");

        // R9: resolve inputs without the branch flag change nothing
        cyc(0, 32'h40, 1'b0, 1'b1, 1'b0, 5, 3, -1, "R9 non-branch", fi, fc);
        cyc(0, 32'h44, 1'b0, 1'b1, 1'b0, 0, 2, -1, "R9 history unchanged", fi, fc);
        probe(5, "R9 entry 5 untouched");
        probe(0, "R9 entry 0 untouched");

        // R7: not-taken on a zero counter holds at zero, history stays 0
        repeat (3) br(0, 32'h100, 1'b0, "R7 low saturation");

        // R8 R6 R7: taken run fills history with ones then saturates entry 63
        repeat (12) br(0, 32'h200, 1'b1, "R8 R6 R7 taken run");
        cyc(0, 32'h200, 1'b0, 1'b0, 1'b0, 0, 0, 1, "R7 entry 63 predicts taken", fi, fc);

        // R8: mixed outcomes visible through the history index
        br(0, 32'h300, 1'b0, "R8 shift N");
        br(0, 32'h300, 1'b1, "R8 shift T");
        br(0, 32'h300, 1'b0, "R8 shift N2");

        // R3: XOR indexing with several addresses
        br(1, 32'h0000_00FC, 1'b1, "R3 xor a");
        br(1, 32'h0000_0A48, 1'b0, "R3 xor b");
        br(1, 32'hFFFF_FF04, 1'b1, "R3 xor c");
        br(1, 32'h0000_0133, 1'b1, "R3 xor d");

        // R4: concatenated indexing
        br(2, 32'h0000_001C, 1'b1, "R4 cat a");
        br(2, 32'h0000_0010, 1'b0, "R4 cat b");
        br(2, 32'h1234_5678, 1'b1, "R4 cat c");
        br(2, 32'h0000_0FFC, 1'b0, "R4 cat d");

        // R2: reserved mode behaves as history only
        br(3, 32'h0000_0ABC, 1'b1, "R2 mode3 a");
        br(3, 32'h0000_0004, 1'b1, "R2 mode3 b");

        // R5: a weak-taken entry predicts taken on the very next read
        probe(17, "R5 pre");
        cyc(1, PC_W'(((17 ^ m_ghr) & MASK) << ALIGN), 1'b0, 1'b0, 1'b0, 0, 0, -1,
            "R5 fetch 17", a_idx, a_ctr);
        cyc(0, 32'h0, 1'b1, 1'b1, 1'b0, 17, 1, -1, "R5 write weak taken", fi, fc);
        probe(17, "R5 weak taken read");

        // R6: update uses the carried index after the history has moved on
        cyc(1, 32'h0000_00A8, 1'b0, 1'b0, 1'b0, 0, 0, -1, "R6 fetch A", a_idx, a_ctr);
        br(2, 32'h0000_0040, 1'b1, "R6 intervening 1");
        br(2, 32'h0000_0044, 1'b1, "R6 intervening 2");
        br(2, 32'h0000_0048, 1'b1, "R6 intervening 3");
        cyc(0, 32'h0, 1'b1, 1'b1, 1'b0, a_idx, a_ctr, -1, "R6 resolve A", fi, fc);
        probe(a_idx, "R6 carried index entry");
        cyc(0, 32'h0, 1'b1, 1'b1, 1'b0, a_idx, 3, -1, "R7 carry 3", fi, fc);
        probe(a_idx, "R7 saturated 3");

        // R1 again, then R10: four-step loop learns its exit
        do_reset();
        probe(63, "R1 entry 63 cleared by reset");
        do_reset();
        for (int rnd = 0; rnd < 9; rnd++) begin
            for (int pos = 0; pos < 4; pos++) begin
                cyc(0, 32'h0000_0800, 1'b1, (pos != 3), 1'b1, 0, 0,
                    (rnd >= 5) ? int'(pos != 3) : -1, "R10 loop", fi, fc);
            end
        end

        @(negedge clk);
        res_branch_i = 1'b0;
        repeat (2) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule